// File: doc/BRIEF.md
# Vertical Blanking Noise Level Detector

This block estimates how noisy a video source is by looking at lines inside the vertical blanking interval, where the picture carries no motion and any sample-to-sample variation is noise. A downstream noise-reduction stage reads the reported values and adjusts its strength automatically. The block watches a luma and a chroma sample stream, along with horizontal sync, a per-line valid indicator, a field identifier and a frame-start pulse. It locates blanking lines by counting from the end of the valid region of each frame.

For each measured blanking line, the block captures a fixed window of samples after horizontal sync. It computes the mean of that window, and then the mean and the peak of the absolute deviations from it. Single-line mode reports one programmed line. Multi-line mode reports the worst of up to sixteen consecutive blanking lines that end at that line. Each frame result goes into an eight-deep history. For each channel, the output is either the latest frame result or the eight-frame average. Outputs update at most once per frame, together with a one-cycle result pulse. They hold while measurement is disabled.

Top module: `nl_blank_noise_det`

## Requirements
- R1: After reset, all four result outputs are 0 and res_valid is 0.
- R2: Blanking lines are numbered from 0, and line 0 is the first line with line_valid low after the last valid line. In single-line mode with cfg_offset=0, the measured line is number cfg_line.
- R3: With cfg_offset=1, every selected line moves one line later. The measured line is number cfg_line+1, and multi-line mode starts at number 1.
- R4: A frame is measured only when field_id, sampled at the horizontal sync of the measured lines, equals cfg_field (0 selects field A, 1 selects field B). Frames of the other field produce no result pulse and leave the outputs unchanged.
- R5: With cfg_multi=1, the lines numbered cfg_offset through cfg_line+cfg_offset are all measured. The frame average is the largest line average among them, and the frame maximum is the largest line maximum among them.
- R6: Per line, the window holds the 8 samples on the 8 cycles after the hsync cycle. Let m be the floor of the window sum divided by 8. The line average is the floor of the sum of |s-m| divided by 8, and the line maximum is the largest |s-m|.
- R7: Each frame result is pushed into an 8-entry history that reset clears to zero. A channel whose single bit (cfg_y_single, cfg_c_single) is 1 reports the new frame value. A bit of 0 reports the floor of the sum of the last 8 pushed values divided by 8. The two channels select independently.
- R8: While cfg_en is 0, no line is measured, no result pulse occurs, and the outputs and the history keep their values.
- R9: A measured frame gives exactly one one-cycle res_valid pulse, after the window of its last measured line. The outputs change only in that cycle.

Ports table follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_y | input | DW | Luma sample |
| pix_c | input | DW | Chroma sample |
| hsync | input | 1 | One-cycle pulse at the start of each line |
| line_valid | input | 1 | Line is a valid picture line, sampled at hsync |
| field_id | input | 1 | Current field, sampled at hsync |
| frame_start | input | 1 | One-cycle pulse before the first line of a frame |
| cfg_en | input | 1 | Measurement enable |
| cfg_line | input | 4 | Target blanking line number |
| cfg_offset | input | 1 | Start counting one line later when 1 |
| cfg_field | input | 1 | Field to measure |
| cfg_multi | input | 1 | Multi-line maximum mode |
| cfg_y_single | input | 1 | Luma reports the latest frame (1) or the 8-frame average (0) |
| cfg_c_single | input | 1 | Chroma reports the latest frame (1) or the 8-frame average (0) |
| y_avg | output | DW | Luma average noise |
| y_max | output | DW | Luma maximum noise |
| c_avg | output | DW | Chroma average noise |
| c_max | output | DW | Chroma maximum noise |
| res_valid | output | 1 | One-cycle pulse when the results update |

## Verification
In a single cycle at the end of the last measured line, the block folds the current line statistics into the multi-line maximum and also commits the folded value into the history and the outputs. The bench provokes this by running multi-line frames in which the per-line patterns vary, so that sometimes the final line is the worst and sometimes an earlier one is. It runs the same frames with averaging enabled, where the history push and the output selection coincide with that fold. Each frame is judged against arithmetic worked out in the bench from the sample pattern: a fold that drops the final line, or uses the accumulator from before the update, gives a wrong value in some of these frames.

// File: rtl/nl_pkg.sv
package nl_pkg;
  localparam int HIST_N     = 8;
  localparam int HIST_SH    = 3;
  localparam int LINE_IDX_W = 4;
  localparam int BCNT_W     = LINE_IDX_W + 1;
endpackage

// File: rtl/nl_line_timing.sv
module nl_line_timing #(
  parameter int WIN = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hsync,
  input  logic                          line_valid,
  input  logic                          field_id,
  input  logic                          frame_start,
  input  logic                          cfg_en,
  input  logic [nl_pkg::LINE_IDX_W-1:0] cfg_line,
  input  logic                          cfg_offset,
  input  logic                          cfg_field,
  input  logic                          cfg_multi,
  output logic                          cap_en,
  output logic                          win_done,
  output logic                          line_first,
  output logic                          line_last
);
  import nl_pkg::*;
  localparam int WCW = $clog2(WIN) + 1;
  localparam logic [BCNT_W-1:0] BC_MAX = '1;

  logic              armed_q, armed_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic              cap_q, cap_d;
  logic [WCW-1:0]    wcnt_q, wcnt_d;
  logic              done_q, done_d;
  logic              first_q, first_d, last_q, last_d;
  logic [BCNT_W-1:0] rel, kk;
  logic              hit;

  always_comb begin
    rel = bcnt_q - {{(BCNT_W-1){1'b0}}, cfg_offset};
    kk  = {1'b0, cfg_line};
    hit = cfg_en && (field_id == cfg_field) &&
          (bcnt_q >= {{(BCNT_W-1){1'b0}}, cfg_offset}) &&
          (cfg_multi ? (rel <= kk) : (rel == kk));
  end

  always_comb begin
    armed_d = armed_q;
    bcnt_d  = bcnt_q;
    cap_d   = cap_q;
    wcnt_d  = wcnt_q;
    first_d = first_q;
    last_d  = last_q;
    done_d  = 1'b0;
    if (cap_q) begin
      wcnt_d = wcnt_q + 1'b1;
      if (wcnt_q == WCW'(WIN - 1)) begin
        cap_d  = 1'b0;
        done_d = 1'b1;
      end
    end
    if (frame_start) begin
      armed_d = 1'b0;
      cap_d   = 1'b0;
    end else if (hsync) begin
      if (line_valid) begin
        armed_d = 1'b1;
        bcnt_d  = '0;
        cap_d   = 1'b0;
      end else if (armed_q) begin
        if (bcnt_q != BC_MAX) bcnt_d = bcnt_q + 1'b1;
        cap_d   = hit;
        wcnt_d  = '0;
        first_d = !cfg_multi || (rel == '0);
        last_d  = (rel == kk);
      end else begin
        cap_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      bcnt_q  <= '0;
      cap_q   <= 1'b0;
      wcnt_q  <= '0;
      done_q  <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      bcnt_q  <= bcnt_d;
      cap_q   <= cap_d;
      wcnt_q  <= wcnt_d;
      done_q  <= done_d;
      first_q <= first_d;
      last_q  <= last_d;
    end
  end

  assign cap_en     = cap_q;
  assign win_done   = done_q;
  assign line_first = first_q;
  assign line_last  = last_q;
endmodule

// File: rtl/nl_line_stat.sv
module nl_line_stat #(
  parameter int DW  = 8,
  parameter int WIN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] pix,
  output logic [DW-1:0] l_avg,
  output logic [DW-1:0] l_max
);
  localparam int LW = $clog2(WIN);
  localparam int SW = DW + LW;

  logic [DW-1:0] buf_q [WIN];
  logic [SW-1:0] sum, dsum;
  logic [DW-1:0] mean, dev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) buf_q[i] <= '0;
    end else if (cap_en) begin
      buf_q[0] <= pix;
      for (int i = 1; i < WIN; i++) buf_q[i] <= buf_q[i-1];
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < WIN; i++) sum = sum + SW'(buf_q[i]);
    mean  = sum[SW-1:LW];
    dsum  = '0;
    l_max = '0;
    dev   = '0;
    for (int i = 0; i < WIN; i++) begin
      dev  = (buf_q[i] >= mean) ? (buf_q[i] - mean) : (mean - buf_q[i]);
      dsum = dsum + SW'(dev);
      if (dev > l_max) l_max = dev;
    end
    l_avg = dsum[SW-1:LW];
  end
endmodule

// File: rtl/nl_avg8.sv
module nl_avg8 #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          single,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  import nl_pkg::*;
  localparam int PW = $clog2(HIST_N);
  localparam int SW = DW + HIST_SH;

  logic [DW-1:0] hist_q [HIST_N];
  logic [PW-1:0] ptr_q;
  logic [SW-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q + SW'(din) - SW'(hist_q[ptr_q]);
    dout  = single ? din : sum_d[SW-1:HIST_SH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST_N; i++) hist_q[i] <= '0;
      ptr_q <= '0;
      sum_q <= '0;
    end else if (push) begin
      hist_q[ptr_q] <= din;
      ptr_q         <= ptr_q + 1'b1;
      sum_q         <= sum_d;
    end
  end
endmodule

// File: rtl/nl_blank_noise_det.sv
module nl_blank_noise_det #(
  parameter int DW  = 8,
  parameter int WIN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pix_y,
  input  logic [DW-1:0] pix_c,
  input  logic          hsync,
  input  logic          line_valid,
  input  logic          field_id,
  input  logic          frame_start,
  input  logic          cfg_en,
  input  logic [3:0]    cfg_line,
  input  logic          cfg_offset,
  input  logic          cfg_field,
  input  logic          cfg_multi,
  input  logic          cfg_y_single,
  input  logic          cfg_c_single,
  output logic [DW-1:0] y_avg,
  output logic [DW-1:0] y_max,
  output logic [DW-1:0] c_avg,
  output logic [DW-1:0] c_max,
  output logic          res_valid
);
  localparam int NCH = 2;
  localparam int NV  = 2 * NCH;

  logic          cap_en, win_done, line_first, line_last, commit;
  logic [DW-1:0] pix    [NCH];
  logic [DW-1:0] l_avg  [NCH];
  logic [DW-1:0] l_max  [NCH];
  logic [DW-1:0] acc_q  [NV];
  logic [DW-1:0] acc_d  [NV];
  logic [DW-1:0] lv     [NV];
  logic [DW-1:0] hout   [NV];
  logic [DW-1:0] res_q  [NV];
  logic [DW-1:0] res_d  [NV];
  logic          vld_q;

  nl_line_timing #(.WIN(WIN)) u_tim (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .line_valid(line_valid),
    .field_id(field_id), .frame_start(frame_start), .cfg_en(cfg_en),
    .cfg_line(cfg_line), .cfg_offset(cfg_offset), .cfg_field(cfg_field),
    .cfg_multi(cfg_multi), .cap_en(cap_en), .win_done(win_done),
    .line_first(line_first), .line_last(line_last)
  );

  assign pix[0] = pix_y;
  assign pix[1] = pix_c;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      nl_line_stat #(.DW(DW), .WIN(WIN)) u_stat (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .pix(pix[c]),
        .l_avg(l_avg[c]), .l_max(l_max[c])
      );
      assign lv[2*c]   = l_avg[c];
      assign lv[2*c+1] = l_max[c];
    end
    for (genvar v = 0; v < NV; v++) begin : g_hist
      nl_avg8 #(.DW(DW)) u_avg (
        .clk(clk), .rst_n(rst_n), .push(commit),
        .single((v < 2) ? cfg_y_single : cfg_c_single),
        .din(acc_d[v]), .dout(hout[v])
      );
    end
  endgenerate

  assign commit = win_done && line_last && cfg_en;

  always_comb begin
    for (int v = 0; v < NV; v++) begin
      acc_d[v] = acc_q[v];
      res_d[v] = res_q[v];
      if (win_done)
        acc_d[v] = (line_first || lv[v] > acc_q[v]) ? lv[v] : acc_q[v];
      if (commit)
        res_d[v] = hout[v];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NV; v++) begin
        acc_q[v] <= '0;
        res_q[v] <= '0;
      end
      vld_q <= 1'b0;
    end else begin
      for (int v = 0; v < NV; v++) begin
        acc_q[v] <= acc_d[v];
        res_q[v] <= res_d[v];
      end
      vld_q <= commit;
    end
  end

  assign y_avg     = res_q[0];
  assign y_max     = res_q[1];
  assign c_avg     = res_q[2];
  assign c_max     = res_q[3];
  assign res_valid = vld_q;
endmodule

// File: rtl/nl_blank_noise_chk.sv
module nl_blank_noise_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic [DW-1:0] y_avg,
  input logic [DW-1:0] y_max,
  input logic [DW-1:0] c_avg,
  input logic [DW-1:0] c_max,
  input logic          res_valid
);
  // R8: no update in the cycle after enable is low
  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!res_valid && $stable(y_avg) && $stable(y_max) &&
                 $stable(c_avg) && $stable(c_max)));

  // R9: the pulse lasts one cycle
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R9: outputs move only together with the pulse
  a_r9_quiet_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(y_avg) && $stable(y_max) &&
                    $stable(c_avg) && $stable(c_max)));

  // R6: mean absolute deviation never exceeds the peak deviation
  a_r6_max_not_below_avg: assert property (@(posedge clk) disable iff (!rst_n)
    (y_max >= y_avg) && (c_max >= c_avg));

  // R1: out of reset the outputs read zero until the first pulse
  a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (y_avg == '0 && y_max == '0 && c_avg == '0 && c_max == '0));
endmodule

bind nl_blank_noise_det nl_blank_noise_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .y_avg(y_avg), .y_max(y_max),
  .c_avg(c_avg), .c_max(c_max), .res_valid(res_valid)
);

// File: tb/sim_nl_blank_noise_det.sv
`timescale 1ns/1ps
module sim_nl_blank_noise_det;
  localparam int DW = 8;
  localparam int NBLANK = 18;
  localparam int LINE_LEN = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic [DW-1:0] pix_y, pix_c;
  logic hsync, line_valid, field_id, frame_start;
  logic cfg_en, cfg_offset, cfg_field, cfg_multi, cfg_y_single, cfg_c_single;
  logic [3:0] cfg_line;
  logic [DW-1:0] y_avg, y_max, c_avg, c_max;
  logic res_valid;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  // expected state: index 0 y_avg, 1 y_max, 2 c_avg, 3 c_max
  int hist [4][8];
  int hptr = 0;
  int exp_o [4];

  always #4 clk = ~clk;

  nl_blank_noise_det #(.DW(DW), .WIN(8)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_y(pix_y), .pix_c(pix_c), .hsync(hsync),
    .line_valid(line_valid), .field_id(field_id), .frame_start(frame_start),
    .cfg_en(cfg_en), .cfg_line(cfg_line), .cfg_offset(cfg_offset),
    .cfg_field(cfg_field), .cfg_multi(cfg_multi), .cfg_y_single(cfg_y_single),
    .cfg_c_single(cfg_c_single), .y_avg(y_avg), .y_max(y_max), .c_avg(c_avg),
    .c_max(c_max), .res_valid(res_valid)
  );

  always @(negedge clk) if (rst_n && res_valid) pulses++;

  function automatic int samp(int f, int raw, int i, int ch);
    return (f * 37 + raw * 11 + ch * 53 + i * (((raw * 5 + f + ch * 3) % 19) + 1) * 7) % 256;
  endfunction

  // R6 arithmetic on one blanking line
  function automatic void line_stat(int f, int raw, int ch, output int la, output int lm);
    int s, m, d, ds;
    s = 0;
    for (int i = 0; i < 8; i++) s += samp(f, raw, i, ch);
    m = s / 8;
    ds = 0; lm = 0;
    for (int i = 0; i < 8; i++) begin
      d = samp(f, raw, i, ch) - m;
      if (d < 0) d = -d;
      ds += d;
      if (d > lm) lm = d;
    end
    la = ds / 8;
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic drive_line(int f, bit valid, int raw);
    for (int c = 0; c < LINE_LEN; c++) begin
      @(negedge clk);
      hsync = (c == 0);
      line_valid = valid;
      field_id = f[0];
      if (c >= 1 && c <= 8 && !valid) begin
        pix_y = DW'(samp(f, raw, c - 1, 0));
        pix_c = DW'(samp(f, raw, c - 1, 1));
      end else begin
        pix_y = DW'(c * 9 + f);
        pix_c = DW'(200 - c);
      end
    end
    @(negedge clk);
    hsync = 0;
  endtask

  task automatic run_frame(int f, string req);
    bit meas;
    int fv [4];
    int la, lm, s, n0, n1;
    meas = cfg_en && (f[0] == cfg_field);
    if (meas) begin
      n0 = cfg_multi ? 0 : int'(cfg_line);
      n1 = int'(cfg_line);
      for (int ch = 0; ch < 2; ch++) begin
        fv[2*ch] = 0; fv[2*ch+1] = 0;
        for (int r = n0; r <= n1; r++) begin
          line_stat(f, r + int'(cfg_offset), ch, la, lm);
          if (la > fv[2*ch]) fv[2*ch] = la;
          if (lm > fv[2*ch+1]) fv[2*ch+1] = lm;
        end
      end
      for (int v = 0; v < 4; v++) begin
        hist[v][hptr] = fv[v];
        s = 0;
        for (int k = 0; k < 8; k++) s += hist[v][k];
        exp_o[v] = ((v < 2) ? cfg_y_single : cfg_c_single) ? fv[v] : s / 8;
      end
      hptr = (hptr + 1) % 8;
    end
    pulses = 0;
    @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
    drive_line(f, 1, 0);
    drive_line(f, 1, 0);
    for (int r = 0; r < NBLANK; r++) drive_line(f, 0, r);
    repeat (3) @(negedge clk);
    check({req, " R9 pulse count"}, pulses, meas ? 1 : 0);
    check({req, " y_avg"}, int'(y_avg), exp_o[0]);
    check({req, " y_max"}, int'(y_max), exp_o[1]);
    check({req, " c_avg"}, int'(c_avg), exp_o[2]);
    check({req, " c_max"}, int'(c_max), exp_o[3]);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f;
    for (int v = 0; v < 4; v++) begin
      exp_o[v] = 0;
      for (int k = 0; k < 8; k++) hist[v][k] = 0;
    end
    rst_n = 0; hsync = 0; line_valid = 0; field_id = 0; frame_start = 0;
    pix_y = 0; pix_c = 0;
    cfg_en = 1; cfg_line = 0; cfg_offset = 0; cfg_field = 0; cfg_multi = 0;
    cfg_y_single = 1; cfg_c_single = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 y_avg", int'(y_avg), 0);
    check("R1 y_max", int'(y_max), 0);
    check("R1 c_avg", int'(c_avg), 0);
    check("R1 c_max", int'(c_max), 0);
    check("R1 res_valid", int'(res_valid), 0);
    f = 0;
    // R2, R3 single line sweep; R4 odd frames must be ignored
    for (int k = 0; k < 16; k++) begin
      cfg_line = 4'(k);
      cfg_offset = k[2];
      run_frame(f, cfg_offset ? "R3 single" : "R2 single"); f++;
      run_frame(f, "R4 other field"); f++;
    end
    // R5 multi-line with field B, both offsets
    cfg_field = 1; cfg_multi = 1;
    f = 41;
    for (int j = 0; j < 8; j++) begin
      cfg_line = 4'((j * 5 + 15) % 16);
      cfg_offset = j[0];
      run_frame(f, "R5 multi"); f += 2;
    end
    // R7 averaging: luma averaged, chroma single, every frame measured
    cfg_multi = 0; cfg_y_single = 0; cfg_c_single = 1;
    for (int j = 0; j < 10; j++) begin
      cfg_line = 4'(j + 3);
      cfg_offset = j[1];
      cfg_field = f[0];
      run_frame(f, "R7 avg y"); f++;
    end
    // R8 disabled frames hold
    cfg_en = 0;
    for (int j = 0; j < 3; j++) begin
      cfg_field = f[0];
      run_frame(f, "R8 hold"); f++;
    end
    // R7 with R5: both channels averaged, multi mode
    cfg_en = 1; cfg_multi = 1; cfg_y_single = 0; cfg_c_single = 0;
    for (int j = 0; j < 5; j++) begin
      cfg_line = 4'(j * 3 + 2);
      cfg_offset = ~j[0];
      cfg_field = f[0];
      run_frame(f, "R7 R5 avg multi"); f++;
    end
    // R9 switch back to single report: latest value, one pulse
    cfg_y_single = 1; cfg_c_single = 1;
    cfg_field = f[0];
    run_frame(f, "R9 single report"); f++;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule